// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Mask

This block gathers sixteen interrupt request inputs, each active low, and gives each one a programmable 4-bit priority level. Each cycle it finds the highest-level pending source. It compares that level with the 4-bit mask level the CPU supplies. The winner is offered to the CPU only when its level is strictly greater than the mask. The offer carries the winning level, which the CPU loads as its new mask, and a vector number. Sources of equal level are ordered by index, and the lowest index wins. A level of 0 turns a source off.

Each source works in one of two sensing modes. A level-sensed source is pending for as long as its input is held low. An edge-sensed source records a falling edge and stays pending until the CPU takes that source. A register port holds the priority fields and the mode bits.

The CPU interface behaves like a valid/ready pair. `cpu_req` is the valid and `cpu_ack` is the ready. A transfer, called a take, happens in any cycle where both are high. While `cpu_ack` stays low the request waits. During the wait, level and vector may be replaced by a higher winner, and the request drops if the winner stops being eligible. After a take, `cpu_req` is low for one cycle and then reflects a fresh arbitration.

The active-low `irq_out_n` indicator goes low whenever a request is offered. After a level-sensed take it rises at once. After an edge-sensed take it stays low until the CPU pulses `cpu_start`, which marks the start of exception processing. If a new request is being offered when that pulse arrives, it stays low.

Top module: `intarb`

## Requirements
- R1: While `rst_n` is low and right after it, `cpu_req` is 0, `irq_out_n` is 1, every priority field is 0 and every source is level-sensed.
- R2: Register address k (0 to 3) holds the priorities of sources 4k to 4k+3. Source 4k+j sits in bits [4j+3:4j]. Address 4 bit i selects edge sensing (1) for source i. Reads return the written values. Addresses 5 to 7 read as 0 and ignore writes.
- R3: Among pending enabled sources, the one with the highest priority level is offered.
- R4: Among pending sources with equal highest level, the lowest index is offered.
- R5: A request is offered only if its level is strictly greater than `cpu_mask`. A level equal to or below the mask gives `cpu_req` = 0.
- R6: A source whose priority field is 0 is never offered.
- R7: An offered request shows `cpu_level` = the source's level and `cpu_vector` = 64 + source index. `cpu_req` follows an input change after exactly one clock edge.
- R8: A level-sensed source is pending only while its input is low and keeps no memory of past lows.
- R9: An edge-sensed source records a falling edge and stays pending after the input returns high. A take of that source clears it.
- R10: After a take, `cpu_req` is 0 for the next cycle and is then re-evaluated.
- R11: `irq_out_n` is 0 while `cpu_req` is 1. After a take of a level-sensed source it is 1 at once (when nothing else is offered). After a take of an edge-sensed source it stays 0 until the cycle after `cpu_start`.
- R12: If a request is being offered when `cpu_start` arrives, `irq_out_n` stays 0.
- R13: `cpu_ack` while `cpu_req` is 0 has no effect, and a recorded edge survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_n | input | 16 | Interrupt request inputs, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| cpu_mask | input | 4 | CPU mask level |
| cpu_ack | input | 1 | CPU takes the offered request (ready) |
| cpu_start | input | 1 | CPU began exception processing |
| cpu_req | output | 1 | Request offered to CPU (valid) |
| cpu_level | output | 4 | Level of offered request |
| cpu_vector | output | 8 | Vector number of offered request |
| irq_out_n | output | 1 | Interrupt-out indicator, active low |

## Verification
The hardest state to reach is an edge-sensed take followed by a preemption. Here `irq_out_n` is held only by the edge hold, and a higher level-sensed request then rises above the newly loaded mask before `cpu_start` arrives. The bench reaches it with a fixed sequence: it pulses an edge source, takes it while raising the mask to its level, asserts a higher level source, and only then pulses `cpu_start`. Around this, sweeps cover every source, level and mask value, and every source pair at higher, lower and equal levels.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] level_t;
endpackage

// File: rtl/intarb_regs.sv
module intarb_regs
  import intarb_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NSRC-1:0][LVL_W-1:0]  prio,
  output logic [NSRC-1:0]             edge_sel
);
  localparam int PER_REG = DATA_W / LVL_W;
  localparam int NPRIO   = NSRC / PER_REG;
  localparam int IDX_W   = (NPRIO > 1) ? $clog2(NPRIO) : 1;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NPRIO);

  logic [NPRIO-1:0][DATA_W-1:0] prio_q;
  logic [DATA_W-1:0]            mode_q;

  for (genvar k = 0; k < NPRIO; k++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   prio_q[k] <= '0;
      else if (we && addr == ADDR_W'(k))            prio_q[k] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         mode_q <= '0;
    else if (we && addr == MODE_ADDR)   mode_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (addr < MODE_ADDR)       rdata = prio_q[addr[IDX_W-1:0]];
    else if (addr == MODE_ADDR) rdata = mode_q;
  end

  assign prio     = prio_q;
  assign edge_sel = mode_q[NSRC-1:0];
endmodule

// File: rtl/intarb_pending.sv
module intarb_pending #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_n,
  input  logic [NSRC-1:0] edge_sel,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] prev_q, flag_q, fell;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign fell[g] = prev_q[g] & ~src_n[g] & edge_sel[g];
    assign pend[g] = edge_sel[g] ? (flag_q[g] | fell[g]) : ~src_n[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b1;
        flag_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= src_n[g];
        flag_q[g] <= edge_sel[g] & ((flag_q[g] & ~clr[g]) | fell[g]);
      end
    end

    assert_edge_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !fell[g]) |=> !flag_q[g]);
  end
endmodule

// File: rtl/intarb_select.sv
module intarb_select
  import intarb_pkg::*;
#(
  parameter int NSRC = 16,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0][LVL_W-1:0] prio,
  output logic                       found,
  output level_t                     best_lvl,
  output logic [SRC_W-1:0]           best_idx
);
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && prio[i] != '0 && prio[i] >= best_lvl) begin
        best_lvl = prio[i];
        best_idx = SRC_W'(i);
      end
    end
    found = (best_lvl != '0);
  end
endmodule

// File: rtl/intarb.sv
module intarb
  import intarb_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  cpu_mask,
  input  logic              cpu_ack,
  input  logic              cpu_start,
  output logic              cpu_req,
  output logic [LVL_W-1:0]  cpu_level,
  output logic [VEC_W-1:0]  cpu_vector,
  output logic              irq_out_n
);
  localparam int SRC_W = $clog2(NSRC);

  logic [NSRC-1:0][LVL_W-1:0] prio;
  logic [NSRC-1:0]            edge_sel, pend, clr;
  logic                       found, take;
  level_t                     sel_lvl;
  logic [SRC_W-1:0]           sel_idx;

  logic             req_q, hold_q;
  level_t           lvl_q;
  logic [SRC_W-1:0] idx_q;

  intarb_regs #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .prio(prio), .edge_sel(edge_sel)
  );

  intarb_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_n(src_n), .edge_sel(edge_sel),
    .clr(clr), .pend(pend)
  );

  intarb_select #(.NSRC(NSRC)) u_sel (
    .pend(pend), .prio(prio), .found(found),
    .best_lvl(sel_lvl), .best_idx(sel_idx)
  );

  assign take = req_q & cpu_ack;
  assign clr  = take ? (NSRC'(1) << idx_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      lvl_q  <= '0;
      idx_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      req_q <= take ? 1'b0 : (found && (sel_lvl > cpu_mask));
      lvl_q <= sel_lvl;
      idx_q <= sel_idx;
      if (take && edge_sel[idx_q]) hold_q <= 1'b1;
      else if (cpu_start)          hold_q <= 1'b0;
    end
  end

  assign cpu_req    = req_q;
  assign cpu_level  = lvl_q;
  assign cpu_vector = VEC_W'(VEC_BASE) + VEC_W'(idx_q);
  assign irq_out_n  = ~(req_q | hold_q);

  assert_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_level > $past(cpu_mask)));
  assert_nonzero_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_level != '0));
  assert_vector_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_vector >= VEC_W'(VEC_BASE) && cpu_vector < VEC_W'(VEC_BASE + NSRC)));
  assert_drop_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ack) |=> !cpu_req);
  assert_hold_until_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out_n && !cpu_req && !cpu_start) |=> !irq_out_n);
endmodule

// File: tb/intarb_test.sv
module intarb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_n = '1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  cpu_mask = '0;
  logic        cpu_ack = 1'b0;
  logic        cpu_start = 1'b0;
  logic        cpu_req;
  logic [3:0]  cpu_level;
  logic [7:0]  cpu_vector;
  logic        irq_out_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [3:0] shadow [16];

  intarb uut (
    .clk(clk), .rst_n(rst_n), .src_n(src_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_mask(cpu_mask),
    .cpu_ack(cpu_ack), .cpu_start(cpu_start), .cpu_req(cpu_req),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector), .irq_out_n(irq_out_n)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic push_prio();
    for (int k = 0; k < 4; k++) begin
      logic [15:0] v;
      v = '0;
      for (int j = 0; j < 4; j++) v[4*j +: 4] = shadow[4*k + j];
      wr(3'(k), v);
    end
  endtask

  task automatic rd_check(string tag, input logic [2:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    check(tag, int'(reg_rdata), int'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req", int'(cpu_req), 0);
    check("R1 irq_out_n", int'(irq_out_n), 1);
    rst_n = 1'b1;
    cyc();
    check("R1 req after", int'(cpu_req), 0);
    rd_check("R1 prio0", 3'd0, 16'h0);
    rd_check("R1 mode", 3'd4, 16'h0);

    // R2 register map
    for (int k = 0; k < 4; k++) wr(3'(k), 16'(k * 16'h1357 + 16'h2468));
    wr(3'd4, 16'hA5C3);
    for (int a = 5; a < 8; a++) wr(3'(a), 16'hFFFF);
    for (int k = 0; k < 4; k++) rd_check("R2 prio", 3'(k), 16'(k * 16'h1357 + 16'h2468));
    rd_check("R2 mode", 3'd4, 16'hA5C3);
    for (int a = 5; a < 8; a++) rd_check("R2 unused", 3'(a), 16'h0);
    wr(3'd4, 16'h0);
    push_prio();

    // R5 R6 R7 R8 sweep: one level-sensed source, every level and mask
    for (int i = 0; i < 16; i++) begin
      src_n = ~(16'(1) << i);
      for (int l = 0; l < 16; l++) begin
        shadow[i] = 4'(l);
        push_prio();
        for (int m = 0; m < 16; m++) begin
          cpu_mask = 4'(m);
          cyc();
          check("R5 R6 req vs mask", int'(cpu_req), (l > m) ? 1 : 0);
          if (l > m) begin
            check("R7 level", int'(cpu_level), l);
            check("R7 vector", int'(cpu_vector), 64 + i);
            check("R11 irq low", int'(irq_out_n), 0);
          end
        end
      end
      shadow[i] = '0;
      src_n = '1;
    end
    push_prio();
    cpu_mask = '0;

    // R3 R4 pair sweep
    for (int i = 0; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        for (int c = 0; c < 3; c++) begin
          int li, lj, win;
          li = (c == 0) ? 5 : (c == 1) ? 9 : 7;
          lj = (c == 0) ? 9 : (c == 1) ? 5 : 7;
          win = (lj > li) ? j : i;
          shadow[i] = 4'(li); shadow[j] = 4'(lj);
          push_prio();
          src_n = ~((16'(1) << i) | (16'(1) << j));
          cyc();
          check((c == 2) ? "R4 tie winner" : "R3 higher wins", int'(cpu_vector), 64 + win);
          check("R3 level", int'(cpu_level), (li > lj) ? li : lj);
          src_n = '1;
          shadow[i] = '0; shadow[j] = '0;
        end
      end
    end
    push_prio();
    cyc();

    // R7 latency, R8 no memory, R10 re-evaluation
    shadow[2] = 4'd8; push_prio();
    src_n[2] = 1'b0;
    #1 check("R7 not before edge", int'(cpu_req), 0);
    cyc();
    check("R7 one edge", int'(cpu_req), 1);
    cpu_ack = 1'b1;
    cyc();
    cpu_ack = 1'b0;
    check("R10 drop after take", int'(cpu_req), 0);
    check("R11 level release", int'(irq_out_n), 1);
    cyc();
    check("R10 re-evaluated", int'(cpu_req), 1);
    src_n[2] = 1'b1;
    cyc();
    check("R8 no memory", int'(cpu_req), 0);

    // R9 R11 edge-sensed source 3
    shadow[3] = 4'd6; push_prio();
    wr(3'd4, 16'h0008);
    src_n[3] = 1'b0; cyc(); src_n[3] = 1'b1;
    check("R9 edge seen", int'(cpu_req), 1);
    cyc();
    check("R9 held after release", int'(cpu_req), 1);
    check("R9 vector", int'(cpu_vector), 67);
    cpu_ack = 1'b1; cpu_mask = 4'd6;
    cyc();
    cpu_ack = 1'b0;
    check("R11 edge hold req", int'(cpu_req), 0);
    check("R11 edge hold irq", int'(irq_out_n), 0);
    cpu_mask = 4'd0;
    cyc();
    check("R9 cleared by take", int'(cpu_req), 0);
    check("R11 still low", int'(irq_out_n), 0);
    cpu_start = 1'b1; cyc(); cpu_start = 1'b0;
    check("R11 release on start", int'(irq_out_n), 1);

    // R12 preemption before start
    shadow[1] = 4'd10; push_prio();
    src_n[3] = 1'b0; cyc(); src_n[3] = 1'b1;
    cyc();
    cpu_ack = 1'b1; cpu_mask = 4'd6;
    cyc();
    cpu_ack = 1'b0;
    src_n[1] = 1'b0;
    cyc();
    check("R12 higher offered", int'(cpu_vector), 65);
    cpu_start = 1'b1; cyc(); cpu_start = 1'b0;
    check("R12 stays low", int'(irq_out_n), 0);
    check("R12 req", int'(cpu_req), 1);
    cpu_ack = 1'b1; cpu_mask = 4'd10;
    cyc();
    cpu_ack = 1'b0;
    check("R11 level release after preempt", int'(irq_out_n), 1);
    src_n[1] = 1'b1; cpu_mask = 4'd0;
    cyc();

    // R13 ack while idle keeps a recorded edge
    cpu_mask = 4'd7;
    src_n[3] = 1'b0; cyc(); src_n[3] = 1'b1;
    cyc();
    check("R13 masked", int'(cpu_req), 0);
    cpu_ack = 1'b1; cyc(); cpu_ack = 1'b0;
    cpu_mask = 4'd0;
    cyc();
    check("R13 edge survives", int'(cpu_req), 1);
    check("R13 vector", int'(cpu_vector), 67);
    cpu_ack = 1'b1; cpu_mask = 4'd6; cyc(); cpu_ack = 1'b0;
    cpu_start = 1'b1; cyc(); cpu_start = 1'b0;
    check("R11 final release", int'(irq_out_n), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule